// File: doc/BRIEF.md
# Timecode Line Deserializer with Check Byte

This block takes one vertical-interval timecode line that has already been sliced into bits. It frames the line from a start pulse, checks and then drops the two sync bits that come before every payload byte, and packs the payload into nine byte registers. While the bits arrive it also folds every bit into an internal check byte. That covers each sync pair and every payload bit, but stops before the final byte field.

Nothing becomes visible while a line is in progress. Once the last bit of a clean line has been taken, the nine bytes, the check byte and an available flag are all updated together on one clock edge.

A host reads the results through a small address/data read port. A single write location acts as a clear strobe. The clear is not stored, and it returns every readback location to zero.

Top module: `tc_line_deser`

## Requirements
- R1: While reset is held (active-low), and after it is released, every read address returns 0.
- R2: `line_start` arms the deserializer and sets the bit index to 0. A bit is taken on each later cycle where `bit_vld` is high. A full line is 90 bits, indexed 0 to 89. A bit strobed in the same cycle as `line_start` is not taken.
- R3: Read address n, for n from 0 to 8, returns payload byte n. That byte is made of line bits 10n+2 through 10n+9. Bit 10n+2 lands in the LSB.
- R4: Read address 9 returns the check byte. It is seeded to 0 at `line_start` and updated as crc <= {crc[6:0], crc[7]^bit} (polynomial x^8+1) for each of bits 0 to 81, in arrival order.
- R5: Read address 10 returns the available flag in bit 0, with bits 7:1 at zero. The flag is 0 until a line has been decoded and 1 afterwards.
- R6: Within each 10-bit slot, the bit at offset 0 must be 1 and the bit at offset 1 must be 0. A wrong sync bit abandons the line, and no readback location changes.
- R7: A new `line_start` that arrives before bit 89 has been taken abandons the partial line and starts a fresh one. No readback location changes.
- R8: Bytes, check byte and flag all change together on the clock edge that follows the edge taking bit 89. At no other time do they change, except through a clear.
- R9: A write to address 11 with data bit 0 set zeroes all readback locations. Writes with bit 0 clear, and writes to any other address, have no effect.
- R10: If a clear falls in the same cycle as a commit, the clear wins and all locations read 0.
- R11: Read addresses 11 to 15 return 0.
- R12: Bits strobed while no line is armed are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Start-of-line pulse |
| bit_vld | input | 1 | Sliced bit strobe |
| bit_val | input | 1 | Sliced bit value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |

## Verification
Two events can land in the same cycle: the commit of a completed line and a host clear. The bench places a clear write in the cycle straight after the final payload bit of a good line, which is exactly the commit cycle. The next read of every location must then show zero rather than the new line. A second collision, a start pulse in the same cycle as a bit strobe, is also provoked. In both cases a behavioural bit-queue model decides the expected outcome, and it is compared with the read port on every clock.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
   localparam int unsigned TCD_BYTES  = 9;
   localparam int unsigned TCD_DATA_W = 8;
   localparam int unsigned TCD_SYNC_W = 2;

   function automatic int unsigned tcd_addr_w(input int unsigned nbytes);
      return $clog2(nbytes + 3);
   endfunction
endpackage

// File: rtl/tcd_frame_tracker.sv
module tcd_frame_tracker #(
   parameter int unsigned NBYTES = 9,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SYNC_W = 2,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 2'b01,
   localparam int unsigned SLOT  = SYNC_W + DATA_W,
   localparam int unsigned SL_W  = $clog2(SLOT),
   localparam int unsigned BI_W  = $clog2(NBYTES),
   localparam int unsigned DP_W  = $clog2(DATA_W),
   localparam int unsigned SI_W  = (SYNC_W > 1) ? $clog2(SYNC_W) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            line_start,
   input  logic            bit_vld,
   input  logic            bit_val,
   output logic            cap_en,
   output logic [BI_W-1:0] cap_byte,
   output logic [DP_W-1:0] cap_pos,
   output logic            crc_en,
   output logic            done
);
   logic            active;
   logic [SL_W-1:0] slot;
   logic [BI_W-1:0] byte_idx;
   logic            take, in_sync, sync_bad, last_slot, last_byte;

   assign take      = active && bit_vld && !line_start;
   assign in_sync   = slot < SL_W'(SYNC_W);
   assign sync_bad  = take && in_sync && (bit_val != SYNC_PAT[slot[SI_W-1:0]]);
   assign last_slot = slot == SL_W'(SLOT - 1);
   assign last_byte = byte_idx == BI_W'(NBYTES - 1);

   assign cap_en   = take && !in_sync;
   assign cap_byte = byte_idx;
   assign cap_pos  = DP_W'(slot - SL_W'(SYNC_W));
   assign crc_en   = take && !(last_byte && !in_sync);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         slot     <= '0;
         byte_idx <= '0;
         done     <= 1'b0;
      end else begin
         done <= take && !sync_bad && last_slot && last_byte;
         if (line_start) begin
            active   <= 1'b1;
            slot     <= '0;
            byte_idx <= '0;
         end else if (take) begin
            if (sync_bad) begin
               active <= 1'b0;
            end else if (last_slot) begin
               slot <= '0;
               if (last_byte) active <= 1'b0;
               else           byte_idx <= byte_idx + 1'b1;
            end else begin
               slot <= slot + 1'b1;
            end
         end
      end
   end

   p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (active && slot == '0 && byte_idx == '0));
   p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot < SL_W'(SLOT));
   p_sync_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_bad |=> !active);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/tcd_crc_accum.sv
module tcd_crc_accum #(
   parameter int unsigned CRC_W = 8,
   parameter logic [CRC_W-1:0] POLY = 8'h01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             en,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   logic [CRC_W-1:0] crc_next;
   logic             fb;

   assign fb = crc[CRC_W-1] ^ din;

   generate
      if (POLY == CRC_W'(1)) begin : g_rotate
         assign crc_next = {crc[CRC_W-2:0], fb};
      end else begin : g_general
         assign crc_next = {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= '0;
      else if (start) crc <= '0;
      else if (en)    crc <= crc_next;
   end

   p_crc_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (crc == '0));
   p_crc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !en) |=> $stable(crc));
endmodule

// File: rtl/tcd_result_bank.sv
module tcd_result_bank #(
   parameter int unsigned NBYTES = 9,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned BI_W  = $clog2(NBYTES),
   localparam int unsigned DP_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [BI_W-1:0]   cap_byte,
   input  logic [DP_W-1:0]   cap_pos,
   input  logic              cap_val,
   input  logic              commit,
   input  logic [DATA_W-1:0] crc_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] A_CRC   = ADDR_W'(NBYTES);
   localparam logic [ADDR_W-1:0] A_AVAIL = ADDR_W'(NBYTES + 1);
   localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(NBYTES + 2);

   logic              clear;
   logic [DATA_W-1:0] shadow [NBYTES];
   logic [DATA_W-1:0] data_q [NBYTES];
   logic [DATA_W-1:0] crc_q;
   logic              avail_q;

   assign clear = wr_en && (wr_addr == A_CLEAR) && wr_data[0];

   for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shadow[gb] <= '0;
         else if (cap_en && cap_byte == BI_W'(gb))
            shadow[gb][cap_pos] <= cap_val;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      data_q[gb] <= '0;
         else if (clear)  data_q[gb] <= '0;
         else if (commit) data_q[gb] <= shadow[gb];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q   <= '0;
         avail_q <= 1'b0;
      end else if (clear) begin
         crc_q   <= '0;
         avail_q <= 1'b0;
      end else if (commit) begin
         crc_q   <= crc_in;
         avail_q <= 1'b1;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr < A_CRC)        rd_data = data_q[rd_addr[BI_W-1:0]];
      else if (rd_addr == A_CRC)  rd_data = crc_q;
      else if (rd_addr == A_AVAIL) rd_data = {{(DATA_W-1){1'b0}}, avail_q};
   end

   p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!avail_q && crc_q == '0));
   p_commit_sets_avail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !clear) |=> avail_q);
   p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !clear) |=> ($stable(avail_q) && $stable(crc_q)));
endmodule

// File: rtl/tc_line_deser.sv
module tc_line_deser
   import tcd_pkg::*;
#(
   parameter int unsigned NBYTES = TCD_BYTES,
   parameter int unsigned DATA_W = TCD_DATA_W,
   parameter int unsigned SYNC_W = TCD_SYNC_W,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 2'b01,
   parameter logic [DATA_W-1:0] CRC_POLY = 8'h01,
   parameter int unsigned ADDR_W = tcd_addr_w(NBYTES),
   localparam int unsigned BI_W = $clog2(NBYTES),
   localparam int unsigned DP_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (NBYTES < 2)                   $error("NBYTES must be at least 2");
      if (DATA_W < 2)                   $error("DATA_W must be at least 2");
      if (SYNC_W < 1)                   $error("SYNC_W must be at least 1");
      if (ADDR_W < $clog2(NBYTES + 3))  $error("ADDR_W too narrow for the read map");
   endgenerate

   logic            cap_en, crc_en, done;
   logic [BI_W-1:0] cap_byte;
   logic [DP_W-1:0] cap_pos;
   logic [DATA_W-1:0] crc;

   tcd_frame_tracker #(
      .NBYTES(NBYTES), .DATA_W(DATA_W), .SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .bit_vld(bit_vld),
      .bit_val(bit_val), .cap_en(cap_en), .cap_byte(cap_byte), .cap_pos(cap_pos),
      .crc_en(crc_en), .done(done)
   );

   tcd_crc_accum #(.CRC_W(DATA_W), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .start(line_start), .en(crc_en),
      .din(bit_val), .crc(crc)
   );

   tcd_result_bank #(.NBYTES(NBYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_byte(cap_byte),
      .cap_pos(cap_pos), .cap_val(bit_val), .commit(done), .crc_in(crc),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   p_no_read_x_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(rd_data));
endmodule

// File: tb/test_tc_line_deser.sv
module test_tc_line_deser;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0, bit_vld = 1'b0, bit_val = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;

   int vectors = 0, fails = 0, cycles = 0;
   bit comparing = 1'b0;
   string scen = "R1";

   always #5 clk = ~clk;

   tc_line_deser i_tc_line_deser (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .bit_vld(bit_vld),
      .bit_val(bit_val), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // behavioural reference model
   logic [7:0] m_data [9] = '{default: 8'h00};
   logic [7:0] m_crc = 8'h00;
   logic       m_avail = 1'b0;
   bit         m_bits [90];
   bit         m_active = 1'b0, m_pend = 1'b0;
   int         m_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 1'b0; m_pend = 1'b0; m_avail = 1'b0; m_crc = 8'h00;
         foreach (m_data[k]) m_data[k] = 8'h00;
      end else begin
         bit pend_now, clr;
         pend_now = m_pend;
         m_pend   = 1'b0;
         clr = wr_en && wr_addr == 4'd11 && wr_data[0];   // R9
         if (clr) begin                                    // R10: clear wins
            m_avail = 1'b0; m_crc = 8'h00;
            foreach (m_data[k]) m_data[k] = 8'h00;
         end else if (pend_now) begin                      // R8
            logic [7:0] c;
            for (int n = 0; n < 9; n++)
               for (int b = 0; b < 8; b++) m_data[n][b] = m_bits[10*n+2+b];
            c = 8'h00;
            for (int i = 0; i <= 81; i++) begin
               bit fb;
               fb = c[7] ^ m_bits[i];
               c = (c << 1) ^ (fb ? 8'h01 : 8'h00);
            end
            m_crc = c;
            m_avail = 1'b1;
         end
         if (line_start) begin
            m_active = 1'b1; m_cnt = 0;
         end else if (m_active && bit_vld) begin
            int s;
            s = m_cnt % 10;
            if ((s == 0 && !bit_val) || (s == 1 && bit_val)) m_active = 1'b0; // R6
            else begin
               m_bits[m_cnt] = bit_val;
               if (m_cnt == 89) begin m_pend = 1'b1; m_active = 1'b0; end
               m_cnt++;
            end
         end
      end
   end

   function automatic logic [7:0] model_read(input logic [3:0] a);
      if (a < 9)   return m_data[a];
      if (a == 9)  return m_crc;
      if (a == 10) return {7'b0, m_avail};
      return 8'h00;
   endfunction

   function automatic string addr_req(input logic [3:0] a);
      if (a < 9)   return "R3";
      if (a == 9)  return "R4";
      if (a == 10) return "R5";
      return "R11";
   endfunction

   always @(negedge clk) begin
      if (comparing) begin
         logic [7:0] exp;
         exp = model_read(rd_addr);
         vectors++;
         if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s (scenario %s) addr %0d: actual %02h expected %02h",
                     addr_req(rd_addr), scen, rd_addr, rd_data, exp);
         end
         rd_addr = rd_addr + 4'd1;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         fails++;
         $display("FAIL R2 watchdog: actual %0d cycles expected below 50000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send_line(input logic [7:0] b [9], input int bad_at, input int stop_at,
                            input int gap, input bit overlap, input bit clr_at_end);
      line_start = 1'b1;
      if (overlap) begin bit_vld = 1'b1; bit_val = 1'b0; end
      @(negedge clk);
      line_start = 1'b0; bit_vld = 1'b0;
      for (int i = 0; i < stop_at; i++) begin
         int s;
         bit v;
         s = i % 10;
         v = (s == 0) ? 1'b1 : (s == 1) ? 1'b0 : b[i/10][s-2];
         if (i == bad_at) v = ~v;
         bit_vld = 1'b1; bit_val = v;
         @(negedge clk);
         if (gap > 0 && (i % gap) == gap - 1) begin
            bit_vld = 1'b0; bit_val = ~v;
            @(negedge clk);
         end
      end
      bit_vld = 1'b0;
      if (clr_at_end) host_write(4'd11, 8'h01);
   endtask

   task automatic rand_bytes(output logic [7:0] b [9]);
      for (int k = 0; k < 9; k++) b[k] = 8'($urandom);
   endtask

   initial begin
      logic [7:0] pat [9];
      idle(3);
      comparing = 1'b1;                 // R1: checked during reset
      idle(20);
      rst_n = 1'b1;
      idle(20);                         // R1: after release

      scen = "R12";                     // bits with nothing armed
      for (int i = 0; i < 30; i++) begin
         bit_vld = 1'b1; bit_val = i[0]; @(negedge clk);
      end
      bit_vld = 1'b0; idle(16);

      scen = "R3";
      pat = '{8'h01, 8'h80, 8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h3C, 8'hC3, 8'h7E};
      send_line(pat, -1, 90, 0, 1'b0, 1'b0); idle(20);

      scen = "R4";
      rand_bytes(pat); send_line(pat, -1, 90, 3, 1'b0, 1'b0); idle(20);

      scen = "R6";
      rand_bytes(pat); send_line(pat, 40, 90, 0, 1'b0, 1'b0); idle(20);
      rand_bytes(pat); send_line(pat, 81, 90, 0, 1'b0, 1'b0); idle(20);

      scen = "R7";
      rand_bytes(pat); send_line(pat, -1, 60, 0, 1'b0, 1'b0);
      rand_bytes(pat); send_line(pat, -1, 89, 0, 1'b0, 1'b0); idle(20);

      scen = "R2";                      // start pulse with a simultaneous strobe
      rand_bytes(pat); send_line(pat, -1, 90, 7, 1'b1, 1'b0); idle(20);

      scen = "R9";
      host_write(4'd11, 8'hFE); idle(16);
      host_write(4'd10, 8'hFF); idle(16);
      host_write(4'd11, 8'h01); idle(16);

      scen = "R8";                      // back to back lines
      rand_bytes(pat); send_line(pat, -1, 90, 0, 1'b0, 1'b0);
      rand_bytes(pat); send_line(pat, -1, 90, 0, 1'b0, 1'b0); idle(20);

      scen = "R10";                     // clear lands on the commit cycle
      rand_bytes(pat); send_line(pat, -1, 90, 0, 1'b0, 1'b1); idle(20);

      scen = "R5";
      for (int r = 0; r < 6; r++) begin
         rand_bytes(pat); send_line(pat, -1, 90, r, 1'b0, 1'b0); idle(16);
      end

      comparing = 1'b0;
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule